// File: doc/BRIEF.md
# Two-Tier Interrupt Status Controller

This block gathers the interrupt causes of a network controller into one 32-bit status word and reduces them to a single level-sensitive interrupt line. Hardware units raise causes with one-cycle event pulses. Host software uses a small register port to read the status word and to read and write a 32-bit enable word. Software acknowledges a cause by writing a one to its bit in the status word.

Each cause belongs to one of two groups, normal or abnormal. Each group has a summary bit in the status word. A summary bit is set when at least one cause of its group is set and also enabled. The interrupt line is raised only through the summary bits. A summary bit counts only when its own enable bit is set.

The summaries are rebuilt on every change, so they can never become stale or be cleared while an enabled cause is still pending.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is held and until the first host or event activity after it, the status word reads 0xF0000000, the enable word reads 0xF3FE0000 and `irq_o` is low. `host_sel_i` = 0 selects the status word on `host_rdata_o` and 1 selects the enable word; the read path is combinational.
- R2: An event pulse on a cause bit sets that status bit at the next clock. The cause bits are 0 to 14, 26 and 27. Event pulses on any other bit, including the summary bits 15 and 16, have no effect. Status bits 17 to 25 and 28 to 31 always hold their reset value, and no write or event changes them.
- R3: A status write (`host_wr_i` with `host_sel_i` = 0) clears each cause bit whose data bit is 1, at the next clock. Cause bits whose data bit is 0 keep their value.
- R4: When an event pulse and a clearing status write hit the same bit in one cycle, the bit ends up set.
- R5: The normal summary is bit 16. At every clock it equals the OR over the normal causes (bits 0 transmit done, 2 transmit buffer unavailable, 6 receive done, 11 timer expired, 14 early receive) of status AND enable.
- R6: The abnormal summary is bit 15. At every clock it equals the OR over the abnormal causes (bits 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26, 27) of status AND enable.
- R7: Writing ones to a summary bit does not leave it cleared while an enabled cause of its group is still set.
- R8: An enable write (`host_wr_i` with `host_sel_i` = 1) stores all 32 data bits unchanged at the next clock. The summaries in that same clock already use the new enable value, including for an event arriving in the same cycle.
- R9: `irq_o` is registered. One clock after the status or enable word takes new values, it equals (status[15] AND enable[15]) OR (status[16] AND enable[16]). A pending summary whose enable bit is clear never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 32 | One-cycle cause pulses, bit-aligned with the status word |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Register select: 0 status, 1 enable |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Selected register contents |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
Two pairs of actions can land in the same cycle: a hardware event and a write-one-to-clear on the same status bit, and a hardware event and an enable write. The bench starts both actions together on one clock edge. The first is judged by the bit staying set while a different bit cleared in the same write drops. The second is judged by the summary bits reflecting the newly written enable word at once, with the interrupt line following one clock later.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int unsigned ISC_W = 32;

  // cause and summary bit positions (host software decodes these)
  localparam int unsigned B_TX_DONE   = 0;
  localparam int unsigned B_TX_STOP   = 1;
  localparam int unsigned B_TX_NOBUF  = 2;
  localparam int unsigned B_TX_JABBER = 3;
  localparam int unsigned B_LINK_PASS = 4;
  localparam int unsigned B_TX_UNDER  = 5;
  localparam int unsigned B_RX_DONE   = 6;
  localparam int unsigned B_RX_NOBUF  = 7;
  localparam int unsigned B_RX_STOP   = 8;
  localparam int unsigned B_RX_WDOG   = 9;
  localparam int unsigned B_TX_EARLY  = 10;
  localparam int unsigned B_TIMER     = 11;
  localparam int unsigned B_LINK_FAIL = 12;
  localparam int unsigned B_BUS_ERR   = 13;
  localparam int unsigned B_RX_EARLY  = 14;
  localparam int unsigned B_SUM_ABN   = 15;
  localparam int unsigned B_SUM_NORM  = 16;
  localparam int unsigned B_GP_PORT   = 26;
  localparam int unsigned B_LINK_CHG  = 27;

  localparam logic [ISC_W-1:0] NORM_MASK =
      (ISC_W'(1) << B_TX_DONE)  | (ISC_W'(1) << B_TX_NOBUF) |
      (ISC_W'(1) << B_RX_DONE)  | (ISC_W'(1) << B_TIMER)    |
      (ISC_W'(1) << B_RX_EARLY);

  localparam logic [ISC_W-1:0] ABN_MASK =
      (ISC_W'(1) << B_TX_STOP)  | (ISC_W'(1) << B_TX_JABBER) |
      (ISC_W'(1) << B_LINK_PASS)| (ISC_W'(1) << B_TX_UNDER)  |
      (ISC_W'(1) << B_RX_NOBUF) | (ISC_W'(1) << B_RX_STOP)   |
      (ISC_W'(1) << B_RX_WDOG)  | (ISC_W'(1) << B_TX_EARLY)  |
      (ISC_W'(1) << B_LINK_FAIL)| (ISC_W'(1) << B_BUS_ERR)   |
      (ISC_W'(1) << B_GP_PORT)  | (ISC_W'(1) << B_LINK_CHG);

  localparam logic [ISC_W-1:0] CAUSE_MASK = NORM_MASK | ABN_MASK;
  localparam logic [ISC_W-1:0] SUM_MASK   =
      (ISC_W'(1) << B_SUM_ABN) | (ISC_W'(1) << B_SUM_NORM);

  localparam logic [ISC_W-1:0] STAT_RST  = 32'hF000_0000;
  localparam logic [ISC_W-1:0] EN_RST    = 32'hF3FE_0000;
  localparam logic [ISC_W-1:0] STAT_HOLD = STAT_RST & ~(CAUSE_MASK | SUM_MASK);

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } isc_sel_e;

endpackage

// File: rtl/isc_group_or.sv
module isc_group_or #(
  parameter int unsigned   W    = isc_pkg::ISC_W,
  parameter logic [W-1:0]  MASK = '0
) (
  input  logic [W-1:0] cause_i,
  input  logic [W-1:0] en_i,
  output logic         hit_o
);

  logic [W-1:0] hitv;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_member
      assign hitv[i] = cause_i[i] & en_i[i];
    end else begin : g_other
      assign hitv[i] = 1'b0;
    end
  end

  assign hit_o = |hitv;

endmodule

// File: rtl/isc_enable_reg.sv
module isc_enable_reg #(
  parameter int unsigned W = isc_pkg::ISC_W
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_d_o,
  output logic [W-1:0] en_q_o
);

  logic [W-1:0] en_q;
  logic [W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  en_q <= isc_pkg::EN_RST;
    else if (wr_i) en_q <= en_d;
  end

  assign en_d_o = en_d;
  assign en_q_o = en_q;

  // R8: an enable write is stored unchanged
  a_r8_enable_store: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wr_i |=> (en_q == $past(wdata_i)));

  // R8: without a write the enable word holds
  a_r8_enable_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !wr_i |=> $stable(en_q));

endmodule

// File: rtl/isc_status_reg.sv
module isc_status_reg #(
  parameter int unsigned W = isc_pkg::ISC_W
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] evt_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_data_i,
  input  logic         sum_norm_i,
  input  logic         sum_abn_i,
  output logic [W-1:0] cause_d_o,
  output logic [W-1:0] stat_q_o
);

  import isc_pkg::*;

  localparam logic [W-1:0] CLR_MASK = CAUSE_MASK | SUM_MASK;

  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic [W-1:0] clr_bits;
  logic [W-1:0] set_bits;
  logic [W-1:0] cause_d;
  logic         stat_ce;

  always_comb begin
    clr_bits = clr_en_i ? (clr_data_i & CLR_MASK) : '0;
    set_bits = evt_i & CAUSE_MASK;
    // set wins over clear on the same bit
    cause_d  = ((stat_q & CAUSE_MASK) & ~clr_bits) | set_bits;
    stat_d   = STAT_HOLD | cause_d;
    stat_d[B_SUM_NORM] = sum_norm_i;
    stat_d[B_SUM_ABN]  = sum_abn_i;
    stat_ce  = (stat_d != stat_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     stat_q <= STAT_RST;
    else if (stat_ce) stat_q <= stat_d;
  end

  assign cause_d_o = cause_d;
  assign stat_q_o  = stat_q;

  // R4: a pulsed cause is set next cycle, whatever the host wrote
  a_r4_event_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((evt_i & CAUSE_MASK) != '0) |=>
      ((stat_q & $past(evt_i & CAUSE_MASK)) == $past(evt_i & CAUSE_MASK)));

  // R3: ones clear, with no event in the way
  a_r3_clear_ones: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (clr_en_i && (evt_i == '0)) |=> ((stat_q & $past(clr_data_i & CAUSE_MASK)) == '0));

  // R3: zeros leave cause bits alone
  a_r3_zeros_keep: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (clr_en_i && (evt_i == '0)) |=>
      ((stat_q & CAUSE_MASK & ~$past(clr_data_i)) ==
       ($past(stat_q) & CAUSE_MASK & ~$past(clr_data_i))));

  // R2: non-cause, non-summary bits never move
  a_r2_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((stat_q & ~CLR_MASK) == STAT_HOLD));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned W           = isc_pkg::ISC_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] evt_i,
  input  logic         host_wr_i,
  input  logic         host_sel_i,
  input  logic [W-1:0] host_wdata_i,
  output logic [W-1:0] host_rdata_o,
  output logic         irq_o
);

  import isc_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe <= '0;
    else          rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_pipe[SYNC_STAGES-1];

  // host decode
  logic wr_stat;
  logic wr_en;
  assign wr_stat = host_wr_i & (host_sel_i == SEL_STATUS);
  assign wr_en   = host_wr_i & (host_sel_i == SEL_ENABLE);

  logic [W-1:0] en_d, en_q;
  logic [W-1:0] cause_d, stat_q;
  logic         sum_norm, sum_abn;

  isc_enable_reg #(.W(W)) u_en (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .wr_i    (wr_en),
    .wdata_i (host_wdata_i),
    .en_d_o  (en_d),
    .en_q_o  (en_q)
  );

  isc_group_or #(.W(W), .MASK(NORM_MASK)) u_norm (
    .cause_i (cause_d),
    .en_i    (en_d),
    .hit_o   (sum_norm)
  );

  isc_group_or #(.W(W), .MASK(ABN_MASK)) u_abn (
    .cause_i (cause_d),
    .en_i    (en_d),
    .hit_o   (sum_abn)
  );

  isc_status_reg #(.W(W)) u_stat (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .evt_i      (evt_i),
    .clr_en_i   (wr_stat),
    .clr_data_i (host_wdata_i),
    .sum_norm_i (sum_norm),
    .sum_abn_i  (sum_abn),
    .cause_d_o  (cause_d),
    .stat_q_o   (stat_q)
  );

  // registered interrupt line
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(stat_q & en_q & SUM_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o        = irq_q;
  assign host_rdata_o = (host_sel_i == SEL_ENABLE) ? en_q : stat_q;

  // R5: normal summary tracks the registered status and enable words
  a_r5_norm_summary: assert property (@(posedge clk_i) disable iff (!rst_n)
    stat_q[B_SUM_NORM] == (|(stat_q & en_q & NORM_MASK)));

  // R6: abnormal summary tracks the registered status and enable words
  a_r6_abn_summary: assert property (@(posedge clk_i) disable iff (!rst_n)
    stat_q[B_SUM_ABN] == (|(stat_q & en_q & ABN_MASK)));

  // R9: the line only rises after an enabled summary was pending
  a_r9_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> $past((stat_q[B_SUM_ABN] & en_q[B_SUM_ABN]) |
                           (stat_q[B_SUM_NORM] & en_q[B_SUM_NORM])));

  // R9: with both summary enables clear a cycle earlier, the line is low
  a_r9_gated: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((en_q & SUM_MASK) == '0) |=> !irq_o);

endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;

  logic        clk;
  logic        rst_n;
  logic [31:0] evt;
  logic        host_wr;
  logic        host_sel;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [31:0] ST0  = 32'hF000_0000;
  localparam logic [31:0] NIS  = 32'h0001_0000;
  localparam logic [31:0] AIS  = 32'h0000_8000;

  irq_status_ctrl u0 (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .evt_i        (evt),
    .host_wr_i    (host_wr),
    .host_sel_i   (host_sel),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    host_sel = sel;
    #1;
    v = host_rdata;
  endtask

  task automatic chk_stat(input string rq, input logic [31:0] exp);
    logic [31:0] v;
    rd(1'b0, v);
    chk(rq, v, exp);
  endtask

  task automatic chk_en(input string rq, input logic [31:0] exp);
    logic [31:0] v;
    rd(1'b1, v);
    chk(rq, v, exp);
  endtask

  task automatic host_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_stat("R1 status reset", ST0);
    chk_en("R1 enable reset", 32'hF3FE_0000);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable_store();
    host_write(1'b1, 32'hDEAD_BEEF);
    chk_en("R8 enable store pattern", 32'hDEAD_BEEF);
    chk_stat("R8 no causes no summary", ST0);
    host_write(1'b1, 32'h0001_0040);
    chk_en("R8 enable store", 32'h0001_0040);
  endtask

  task automatic t_normal_path();
    pulse(32'h0000_0040);
    chk_stat("R2 R5 receive done sets cause and normal summary", ST0 | 32'h40 | NIS);
    chk("R9 irq one cycle late", {31'b0, irq}, 32'h0);
    settle();
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_abnormal_path();
    host_write(1'b1, 32'h0000_A000);
    chk_stat("R5 normal summary drops with enable", ST0 | 32'h40);
    settle();
    chk("R9 irq drops", {31'b0, irq}, 32'h0);
    pulse(32'h0000_2000);
    chk_stat("R6 bus error sets abnormal summary", ST0 | 32'h2040 | AIS);
    chk("R9 irq not yet", {31'b0, irq}, 32'h0);
    settle();
    chk("R9 irq from abnormal", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_clear();
    host_write(1'b0, 32'h0000_2000);
    chk_stat("R3 clear one cause, zeros keep", ST0 | 32'h40);
    settle();
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_summary_sticky();
    host_write(1'b1, 32'h0001_0040);
    chk_stat("R5 summary on enable write", ST0 | 32'h40 | NIS);
    host_write(1'b0, 32'h0001_0000);
    chk_stat("R7 summary rebuilt after clear", ST0 | 32'h40 | NIS);
    host_write(1'b0, 32'h0001_8000);
    chk_stat("R7 both summaries written", ST0 | 32'h40 | NIS);
    host_write(1'b0, 32'hFFFF_FFFF);
    chk_stat("R2 R3 clear all keeps fixed bits", ST0);
  endtask

  task automatic t_event_vs_clear();
    pulse(32'h0000_0001);
    chk_stat("R2 transmit done set", ST0 | 32'h1);
    @(negedge clk);
    evt = 32'h0000_0040;
    host_sel = 1'b0; host_wr = 1'b1; host_wdata = 32'h0000_0041;
    @(negedge clk);
    evt = '0; host_wr = 1'b0; host_wdata = '0;
    chk_stat("R4 event wins, other bit cleared", ST0 | 32'h40 | NIS);
  endtask

  task automatic t_enable_with_event();
    @(negedge clk);
    evt = 32'h0000_2000;
    host_sel = 1'b1; host_wr = 1'b1; host_wdata = 32'h0000_A000;
    @(negedge clk);
    evt = '0; host_wr = 1'b0; host_wdata = '0;
    chk_stat("R8 R6 new enable used same cycle", ST0 | 32'h2040 | AIS);
    chk_en("R8 enable stored with event", 32'h0000_A000);
    settle();
    chk("R9 irq after enable and event", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_ignored_bits();
    host_write(1'b0, 32'hFFFF_FFFF);
    pulse(32'hF3FF_8000);
    chk_stat("R2 non-cause events ignored", ST0);
    settle();
    chk("R2 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_cause_sweep();
    host_write(1'b1, 32'h0C01_FFFF);
    for (int b = 0; b < 28; b++) begin
      if (b < 15 || b >= 26) begin
        logic [31:0] exp;
        bit is_norm;
        is_norm = (b == 0) || (b == 2) || (b == 6) || (b == 11) || (b == 14);
        exp = ST0 | (32'h1 << b) | (is_norm ? NIS : AIS);
        host_write(1'b0, 32'hFFFF_FFFF);
        pulse(32'h1 << b);
        chk_stat(is_norm ? "R5 normal cause sweep" : "R6 abnormal cause sweep", exp);
      end
    end
  endtask

  task automatic t_summary_gate();
    host_write(1'b1, 32'h0000_0040);
    host_write(1'b0, 32'hFFFF_FFFF);
    pulse(32'h0000_0040);
    chk_stat("R5 summary set without summary enable", ST0 | 32'h40 | NIS);
    settle();
    settle();
    chk("R9 gated by summary enable", {31'b0, irq}, 32'h0);
    host_write(1'b1, 32'h0001_0040);
    chk("R9 not before enable registered", {31'b0, irq}, 32'h0);
    settle();
    chk("R9 raised by enable write", {31'b0, irq}, 32'h1);
    host_write(1'b0, 32'hFFFF_FFFF);
    settle();
    chk("R9 low after clear all", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable_store();
    t_normal_path();
    t_abnormal_path();
    t_clear();
    t_summary_sticky();
    t_event_vs_clear();
    t_enable_with_event();
    t_ignored_bits();
    t_cause_sweep();
    t_summary_gate();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule